// File: doc/BRIEF.md
# Dual-LUT Arithmetic Logic Cell

This block is one tile of a configurable logic fabric. Two small lookup tables share their low address inputs. A configuration word decides how their outputs are combined. In logic mode, the fourth input picks one table or the other, so the pair behaves as one 16-entry truth table. In arithmetic mode, the two table outputs are the operands of a one-bit full adder. The carry comes in from a neighbouring tile and leaves for the next one.

The cell result can leave the tile directly, or it can pass through a flip-flop first. That flip-flop has a clock enable and a synchronous reset. The configuration word is loaded through a one-cycle write strobe. Every pin is a plain level signal with no handshake, because the tile consumes and produces one bit per cycle with no back-pressure. Routing between tiles is outside this block.

Top module: `lcell_top`

## Requirements
- R1: When `rst` is high at a rising edge, the configuration and the flip-flop clear to 0. Afterwards `logic_out` and `carry_out` read 0 for every `din` and `carry_in` until new configuration is written.
- R2: When `cfg_we` is high at a rising edge, `cfg_data` is loaded and governs the outputs from that edge on. Before that edge, the previous configuration still applies. When `cfg_we` is low, the configuration is unchanged.
- R3: Configuration field positions are fixed. Bits [7:0] are table A and bits [15:8] are table B. Each table returns the bit indexed by `din[2:0]`.
- R4: With bit 16 = 0 (logic mode), the cell result is `cfg[{din[3],din[2:0]}]`. That is table A when `din[3]`=0 and table B when `din[3]`=1.
- R5: With bit 16 = 1 (arithmetic mode), the cell result is A xor B xor `carry_in`, and `din[3]` has no effect.
- R6: In both modes, `carry_out` is the majority of A, B and `carry_in`.
- R7: With bit 17 = 0, `logic_out` follows the cell result combinationally. With bit 17 = 1, `logic_out` shows the value captured at the last rising edge where `ce` was high.
- R8: While `ce` is low, the flip-flop holds its value across rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 18 | Configuration word (table A, table B, mode, register select) |
| ce | input | 1 | Flip-flop clock enable |
| din | input | 4 | Cell data inputs |
| carry_in | input | 1 | Carry from the neighbouring tile |
| logic_out | output | 1 | Cell output, registered or combinational |
| carry_out | output | 1 | Carry to the next tile |

## Verification
Some behaviours are checked on every cycle:
- a configuration write lands on the following edge;
- the flip-flop captures the pre-register result when enabled and holds it when not;
- reset clears both storage elements;
- the carry equals whichever operand value the two table outputs agree on, or equals `carry_in` when they disagree.

Other behaviours can only be shown by the bench's scenarios. The bench sweeps every input pattern and carry under several truth tables in both modes. It also covers:
- the ordering of a write against the output;
- the registered and held paths as seen at the pins;
- the reset scenario.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int unsigned CELL_K = 3;

  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int unsigned K = 3,
  localparam int unsigned DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [K-1:0]     addr,
  output logic             bit_out
);
  always_comb bit_out = table_bits[addr];
endmodule

// File: rtl/lcell_fa.sv
module lcell_fa (
  input  logic op_a,
  input  logic op_b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic half;
  always_comb begin
    half = op_a ^ op_b;
    sum  = half ^ cin;
    cout = (op_a & op_b) | (half & cin);
  end
endmodule

// File: rtl/lcell_out.sv
module lcell_out (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic reg_sel,
  input  logic d,
  output logic ff_q,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     ff_q <= 1'b0;
    else if (ce) ff_q <= d;
  end

  always_comb q = reg_sel ? ff_q : d;
endmodule

// File: rtl/lcell_top.sv
module lcell_top #(
  parameter int unsigned K = lcell_pkg::CELL_K,
  localparam int unsigned TBL_W = 1 << K,
  localparam int unsigned CFG_W = 2 * TBL_W + 2,
  localparam int unsigned MODE_BIT = 2 * TBL_W,
  localparam int unsigned REG_BIT = 2 * TBL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             ce,
  input  logic [K:0]       din,
  input  logic             carry_in,
  output logic             logic_out,
  output logic             carry_out
);
  import lcell_pkg::*;

  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       lut_o;
  logic             lut_a, lut_b;
  logic             merged, fa_sum, cell_res, ff_q;
  cell_mode_e       mode;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_data;
  end

  always_comb mode = cell_mode_e'(cfg_q[MODE_BIT]);

  for (genvar g = 0; g < 2; g++) begin : g_lut
    lcell_lut #(.K(K)) u_lut (
      .table_bits(cfg_q[g*TBL_W +: TBL_W]),
      .addr      (din[K-1:0]),
      .bit_out   (lut_o[g])
    );
  end

  always_comb begin
    lut_a  = lut_o[0];
    lut_b  = lut_o[1];
    merged = din[K] ? lut_b : lut_a;
  end

  lcell_fa u_fa (
    .op_a(lut_a),
    .op_b(lut_b),
    .cin (carry_in),
    .sum (fa_sum),
    .cout(carry_out)
  );

  always_comb cell_res = (mode == MODE_ARITH) ? fa_sum : merged;

  lcell_out u_out (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .reg_sel(cfg_q[REG_BIT]),
    .d      (cell_res),
    .ff_q   (ff_q),
    .q      (logic_out)
  );
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk #(
  parameter int unsigned CFG_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_data,
  input logic [CFG_W-1:0] cfg_q,
  input logic             ce,
  input logic             carry_in,
  input logic             lut_a,
  input logic             lut_b,
  input logic             cell_res,
  input logic             ff_q,
  input logic             carry_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == '0 && ff_q == 1'b0));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_q == $past(cfg_data));

  // R2
  cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_q));

  // R6
  carry_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (lut_a == lut_b) |-> carry_out == lut_a);

  // R6
  carry_prop_chk: assert property (@(posedge clk) disable iff (rst)
    (lut_a != lut_b) |-> carry_out == carry_in);

  // R7
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> ff_q == $past(cell_res));

  // R8
  ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(ff_q));
endmodule

bind lcell_top lcell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_data (cfg_data),
  .cfg_q    (cfg_q),
  .ce       (ce),
  .carry_in (carry_in),
  .lut_a    (lut_a),
  .lut_b    (lut_b),
  .cell_res (cell_res),
  .ff_q     (ff_q),
  .carry_out(carry_out)
);

// File: tb/test_lcell_top.sv
module test_lcell_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [17:0] cfg_data = '0;
  logic        ce = 1'b0;
  logic [3:0]  din = '0;
  logic        carry_in = 1'b0;
  logic        logic_out, carry_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcell_top i_lcell_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data), .ce(ce),
    .din(din), .carry_in(carry_in), .logic_out(logic_out), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (din=%h cin=%b)", req, act, exp, din, carry_in);
    end
  endtask

  task automatic write_cfg(input logic [17:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic exp_out(input logic [17:0] c, input logic [3:0] d, input logic ci);
    logic a, b;
    a = c[{1'b0, d[2:0]}];
    b = c[{1'b1, d[2:0]}];
    if (c[16]) return a ^ b ^ ci;
    return d[3] ? b : a;
  endfunction

  function automatic logic exp_cy(input logic [17:0] c, input logic [3:0] d, input logic ci);
    int s;
    s = int'(c[{1'b0, d[2:0]}]) + int'(c[{1'b1, d[2:0]}]) + int'(ci);
    return s >= 2;
  endfunction

  initial begin
    logic [15:0] tables [4];
    logic [17:0] w;
    tables[0] = 16'h6996; tables[1] = 16'hF0CC;
    tables[2] = 16'h8001; tables[3] = 16'h3A5C;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    carry_in = 1'b1; din = 4'hF; #1;
    check("R1", logic_out, 1'b0);
    check("R1", carry_out, 1'b0);

    // R3 R4 R5 R6: exhaustive sweep, combinational output
    for (int t = 0; t < 4; t++) begin
      for (int m = 0; m < 2; m++) begin
        w = {1'b0, 1'(m), tables[t]};
        write_cfg(w);
        for (int d = 0; d < 16; d++) begin
          for (int c = 0; c < 2; c++) begin
            din = 4'(d); carry_in = 1'(c); #1;
            check(m ? "R5" : "R4", logic_out, exp_out(w, din, carry_in));
            check("R6", carry_out, exp_cy(w, din, carry_in));
          end
        end
      end
    end

    // R5: in3 ignored in arithmetic mode
    w = {2'b01, 16'h5A3C};
    write_cfg(w);
    for (int d = 0; d < 8; d++) begin
      logic lo;
      din = 4'(d); carry_in = 1'b1; #1;
      lo = logic_out;
      din[3] = 1'b1; #1;
      check("R5", logic_out, lo);
    end

    // R2: write ordering
    w = {2'b00, 16'h00FF};
    write_cfg(w);
    din = 4'h2; #1;
    check("R2", logic_out, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = {2'b00, 16'hFF00}; #1;
    check("R2", logic_out, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = {2'b00, 16'h00FF}; #1;
    check("R2", logic_out, 1'b0);
    @(negedge clk); #1;
    check("R2", logic_out, 1'b0);

    // R7: registered output
    w = {2'b10, 16'h6996};
    write_cfg(w);
    ce = 1'b1;
    for (int d = 0; d < 16; d++) begin
      logic e;
      din = 4'(d); carry_in = 1'b0;
      e = exp_out(w, din, 1'b0);
      #1;
      @(posedge clk);
      @(negedge clk);
      din = ~din; #1;
      check("R7", logic_out, e);
    end

    // R8: hold with ce low
    din = 4'h1; @(posedge clk); @(negedge clk); #1;
    check("R7", logic_out, 1'b1);
    ce = 1'b0; din = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R8", logic_out, 1'b1);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; din = 4'h1; carry_in = 1'b1; #1;
    check("R1", logic_out, 1'b0);
    check("R1", carry_out, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule